// File: doc/BRIEF.md
# System Global Control Register File

This block is a bank of 32-bit control and status words that sits in a 4 KiB address window behind a simple word-wide read/write strobe interface. Software reaches each word by its byte offset. Every word carries its own access policy. Some words are read-only. Some are cleared by writing ones, and some are sticky words where a written one can never be removed. All the remaining words store whatever is written.

A cold reset loads every word with a fixed value. Three words are the exception. A strap word captures the board strap pins. A module-disable word captures the disabled-module configuration. A memory configuration word combines a fixed base pattern with a compact code for the size of the attached DRAM. The DRAM size is given as a 3-bit power-of-two code k, where the size is 128 MiB shifted left by k, so k runs from 0 to 4. A code outside that range is clamped to 4 and flagged on an error output.

Top module: `sysctl_regfile`

## Requirements
- R1: The word index is bus_addr[11:2], and words exist at indices 0 to 81 (byte offsets 0x000 to 0x144). A read at a higher index, or with bus_addr[1:0] not equal to 0, returns 0. A write there changes no word.
- R2: Writes to offsets 0x000 (identity word), 0x004 (strap word) and 0x040 (interrupt status word) are discarded.
- R3: Offsets 0x06C (reset cause word) and 0x0D4 (coprocessor status word) update as old AND NOT data, so a written one clears that bit and a written zero leaves it unchanged.
- R4: Offsets 0x070 (lock word) and 0x07C (module-disable word) update as old OR data. A set bit stays set until the next reset.
- R5: Every other in-range word stores the full 32-bit write data.
- R6: After reset the words read as follows, and every word not listed reads 0:
  - 0x000 = 0x04A92750
  - 0x014 = 0x0000FFFF
  - 0x038 = 0x00000003
  - 0x03C = 0x0000035E
  - 0x050 = 0x0000004E
  - 0x060 = 0x00080000
  - 0x06C = 0x80000000
  - 0x078 = 0x000000C0
  - 0x098 = 0x5A00F3CF
  - 0x13C = 0x00000008
  - 0x140 = 0x034730E4
  - 0x144 = 0x034730E4
- R7: During reset (rst_n low, held synchronously) the strap word 0x004 loads strap_in and the module-disable word 0x07C loads mod_off_in.
- R8: During reset, word 0x09C loads 0x00001002 OR (k << 8), where k = dram_code if dram_code <= 4 and k = 4 otherwise. cfg_err is 1 exactly while dram_code > 4.
- R9: bus_rdata is registered. It shows the addressed word in the cycle after bus_rd. If a write hits the same word in the same cycle, the read returns the value from before that write. While bus_rd is low, bus_rdata holds its value, and it resets to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low cold reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| strap_in | input | 32 | Strap pin values captured at reset |
| mod_off_in | input | 32 | Disabled-module mask captured at reset |
| dram_code | input | 3 | DRAM size code k (size = 128 MiB << k) |
| cfg_err | output | 1 | DRAM size code out of range |

## Verification
The assertions assume three things about the inputs. Reset is held low for at least one clock edge. The strobes are sampled only at rising edges. dram_code is stable whenever rst_n is low. The bench changes inputs only on falling edges and changes dram_code only together with a fresh reset. It keeps reset low for several cycles, so every word's captured value comes from a settled input. Misaligned and beyond-the-end offsets are driven on purpose, because the read-as-zero property covers them.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int WORD_W = 32;

  // Word indices whose behaviour depends on position
  localparam int IDX_ID     = 0;
  localparam int IDX_STRAP  = 1;
  localparam int IDX_ISTAT  = 16;
  localparam int IDX_RCAUSE = 27;
  localparam int IDX_LOCK   = 28;
  localparam int IDX_MODOFF = 31;
  localparam int IDX_MEMCFG = 39;
  localparam int IDX_CPSTAT = 53;

  localparam logic [WORD_W-1:0] ID_VALUE    = 32'h04A9_2750;
  localparam logic [WORD_W-1:0] MEMCFG_BASE = 32'h0000_1002;
  localparam int                MEMCFG_SHIFT = 8;

  typedef enum logic [1:0] {POL_RW, POL_RO, POL_W1C, POL_W1S} pol_t;

  function automatic pol_t policy_of(input int idx);
    case (idx)
      IDX_ID, IDX_STRAP, IDX_ISTAT: return POL_RO;
      IDX_RCAUSE, IDX_CPSTAT:       return POL_W1C;
      IDX_LOCK, IDX_MODOFF:         return POL_W1S;
      default:                      return POL_RW;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] reset_const(input int idx);
    case (idx)
      IDX_ID:     return ID_VALUE;
      5:          return 32'h0000_FFFF;
      14:         return 32'h0000_0003;
      15:         return 32'h0000_035E;
      20:         return 32'h0000_004E;
      24:         return 32'h0008_0000;
      IDX_RCAUSE: return 32'h8000_0000;
      30:         return 32'h0000_00C0;
      38:         return 32'h5A00_F3CF;
      79:         return 32'h0000_0008;
      80, 81:     return 32'h0347_30E4;
      default:    return '0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] apply_write(input pol_t p,
      input logic [WORD_W-1:0] old, input logic [WORD_W-1:0] wd);
    case (p)
      POL_RO:  return old;
      POL_W1C: return old & ~wd;
      POL_W1S: return old | wd;
      default: return wd;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode #(
  parameter int ADDR_W    = 12,
  parameter int NUM_WORDS = 82,
  localparam int IDX_W    = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              in_range
);
  logic aligned;
  assign idx      = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign in_range = aligned && (idx < IDX_W'(NUM_WORDS));
endmodule

// File: rtl/sysctl_dram_enc.sv
module sysctl_dram_enc #(
  parameter int CODE_W = 3,
  parameter int MAX_K  = 4
) (
  input  logic [CODE_W-1:0] code,
  output logic [31:0]       field,
  output logic              err
);
  logic [CODE_W-1:0] k;
  assign err   = code > CODE_W'(MAX_K);
  assign k     = err ? CODE_W'(MAX_K) : code;
  assign field = sysctl_pkg::MEMCFG_BASE | (32'(k) << sysctl_pkg::MEMCFG_SHIFT);
endmodule

// File: rtl/sysctl_word.sv
module sysctl_word #(
  parameter sysctl_pkg::pol_t POL = sysctl_pkg::POL_RW,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] rst_val,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= rst_val;
    else if (we) q <= sysctl_pkg::apply_write(POL, q, wdata);
  end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile #(
  parameter int ADDR_W    = 12,
  parameter int NUM_WORDS = 82,
  parameter int CODE_W    = 3,
  parameter int MAX_K     = 4,
  localparam int IDX_W    = ADDR_W - 2,
  localparam int WORD_W   = sysctl_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [WORD_W-1:0] strap_in,
  input  logic [WORD_W-1:0] mod_off_in,
  input  logic [CODE_W-1:0] dram_code,
  output logic              cfg_err
);
  logic [IDX_W-1:0]  acc_idx;
  logic              acc_ok;
  logic              wr_hit;
  logic              rd_hit;
  logic [WORD_W-1:0] memcfg_rst;
  logic [WORD_W-1:0] rd_val;
  logic [WORD_W-1:0] word_q [NUM_WORDS];

  sysctl_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_dec (
    .addr(bus_addr), .idx(acc_idx), .in_range(acc_ok));

  sysctl_dram_enc #(.CODE_W(CODE_W), .MAX_K(MAX_K)) u_enc (
    .code(dram_code), .field(memcfg_rst), .err(cfg_err));

  assign wr_hit = bus_wr && acc_ok;
  assign rd_hit = bus_rd && acc_ok;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    logic [WORD_W-1:0] rv;
    if (i == sysctl_pkg::IDX_STRAP) begin : g_strap
      assign rv = strap_in;
    end else if (i == sysctl_pkg::IDX_MODOFF) begin : g_modoff
      assign rv = mod_off_in;
    end else if (i == sysctl_pkg::IDX_MEMCFG) begin : g_memcfg
      assign rv = memcfg_rst;
    end else begin : g_const
      assign rv = sysctl_pkg::reset_const(i);
    end
    sysctl_word #(.POL(sysctl_pkg::policy_of(i)), .WORD_W(WORD_W)) u_word (
      .clk(clk), .rst_n(rst_n), .rst_val(rv),
      .we(wr_hit && (acc_idx == IDX_W'(i))), .wdata(bus_wdata),
      .q(word_q[i]));
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_WORDS; i++)
      if (acc_idx == IDX_W'(i)) rd_val = word_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_hit ? rd_val : '0;
  end
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk #(
  parameter int ADDR_W    = 12,
  parameter int NUM_WORDS = 82,
  parameter int MAX_K     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic [31:0]       rcause_q,
  input logic [31:0]       lock_q,
  input logic [31:0]       memcfg_q
);
  p_oor_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr[1:0] != 2'b00 || bus_addr[ADDR_W-1:2] >= (ADDR_W-2)'(NUM_WORDS)))
    |=> bus_rdata == 32'h0);

  p_id_readonly_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == '0) |=> bus_rdata == sysctl_pkg::ID_VALUE);

  p_w1c_no_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (rcause_q & ~$past(rcause_q)) == 32'h0);

  p_w1s_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (lock_q & $past(lock_q)) == $past(lock_q));

  p_memcfg_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> memcfg_q[10:8] <= 3'(MAX_K));

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !bus_rd) |=> $stable(bus_rdata));
endmodule

bind sysctl_regfile sysctl_regfile_chk #(
  .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .MAX_K(MAX_K)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata),
  .rcause_q(word_q[sysctl_pkg::IDX_RCAUSE]),
  .lock_q(word_q[sysctl_pkg::IDX_LOCK]),
  .memcfg_q(word_q[sysctl_pkg::IDX_MEMCFG]));

// File: tb/sysctl_regfile_test.sv
module sysctl_regfile_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_rd = 0, bus_wr = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [31:0] strap_in = 0, mod_off_in = 0;
  logic [2:0]  dram_code = 0;
  logic        cfg_err;

  int n_chk = 0, n_fail = 0;
  logic [31:0] mdl [82];
  logic [31:0] exp_rd = 0;

  always #10 clk = ~clk;

  sysctl_regfile uut (.clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .strap_in(strap_in), .mod_off_in(mod_off_in), .dram_code(dram_code),
    .cfg_err(cfg_err));

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] fixed_val(input int off);
    case (off)
      'h000: return 32'h04A92750; 'h014: return 32'h0000FFFF;
      'h038: return 32'h00000003; 'h03C: return 32'h0000035E;
      'h050: return 32'h0000004E; 'h060: return 32'h00080000;
      'h06C: return 32'h80000000; 'h078: return 32'h000000C0;
      'h098: return 32'h5A00F3CF; 'h13C: return 32'h00000008;
      'h140: return 32'h034730E4; 'h144: return 32'h034730E4;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input int off);
    if (off[1:0] != 0 || off > 'h144) return "R1";
    if (off == 'h000 || off == 'h004 || off == 'h040) return "R2";
    if (off == 'h06C || off == 'h0D4) return "R3";
    if (off == 'h070 || off == 'h07C) return "R4";
    return "R5";
  endfunction

  // One bus cycle: drive at a falling edge, compare the result one edge later
  task automatic cyc(input bit rd, input bit wr, input int off,
                     input logic [31:0] d, input string tag);
    bit valid;
    valid = (off[1:0] == 0) && (off <= 'h144);
    bus_rd = rd; bus_wr = wr; bus_addr = 12'(off); bus_wdata = d;
    if (rd) exp_rd = valid ? mdl[off/4] : 32'h0;
    if (wr && valid) begin
      case (tag_of(off))
        "R2": ;
        "R3": mdl[off/4] = mdl[off/4] & ~d;
        "R4": mdl[off/4] = mdl[off/4] | d;
        default: mdl[off/4] = d;
      endcase
    end
    @(negedge clk);
    bus_rd = 0; bus_wr = 0;
    check(bus_rdata === exp_rd, (tag == "") ? tag_of(off) : tag, bus_rdata, exp_rd);
  endtask

  task automatic rd(input int off, input string tag = "");
    cyc(1, 0, off, 0, tag);
  endtask
  task automatic wr(input int off, input logic [31:0] d);
    cyc(0, 1, off, d, "R9");
  endtask

  task automatic do_reset(input logic [31:0] s, input logic [31:0] m,
                          input logic [2:0] c);
    int k;
    rst_n = 0; strap_in = s; mod_off_in = m; dram_code = c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    k = (c > 4) ? 4 : int'(c);
    for (int i = 0; i < 82; i++) mdl[i] = fixed_val(i*4);
    mdl[1] = s; mdl[31] = m; mdl[39] = 32'h1002 | (k << 8);
    exp_rd = 0;
    check(bus_rdata === 0, "R9 reset rdata", bus_rdata, 0);
    check(cfg_err === (c > 4), "R8 cfg_err", 32'(cfg_err), 32'(c > 4));
  endtask

  initial begin
    @(negedge clk);
    do_reset(32'h1234ABCD, 32'h00F0000F, 3'd2);
    // R6 R7 R8: every word after reset
    for (int i = 0; i < 82; i++) begin
      string t;
      t = (i == 1 || i == 31) ? "R7" : (i == 39) ? "R8" : "R6";
      rd(i*4, t);
    end
    check(mdl[39] == 32'h1202, "R8 k=2", mdl[39], 32'h1202);
    // R1: beyond the end and misaligned
    rd('h148); rd('hFFC); rd('h001); rd('h016);
    wr('h148, 32'hDEADBEEF); rd('h148); rd('h144, "R1");
    wr('h016, 32'h11111111); rd('h014, "R1");
    wr('hFFC, 32'h22222222); rd('h000, "R1");
    // R2: read-only words
    wr('h000, 32'hFFFFFFFF); wr('h004, 32'h0); wr('h040, 32'hFFFFFFFF);
    rd('h000); rd('h004); rd('h040);
    // R3: write-1-to-clear
    wr('h06C, 32'h7FFFFFFF); rd('h06C);
    wr('h06C, 32'h80000001); rd('h06C);
    wr('h0D4, 32'hFFFFFFFF); rd('h0D4);
    // R4: write-1-to-set, sticky
    wr('h070, 32'h000000A5); rd('h070);
    wr('h070, 32'h00000F00); rd('h070);
    wr('h070, 32'h0); rd('h070);
    wr('h07C, 32'h30000000); rd('h07C);
    wr('h07C, 32'h0); rd('h07C);
    // R5: plain words, several patterns
    wr('h014, 32'h5555AAAA); rd('h014);
    wr('h09C, 32'hCAFEF00D); rd('h09C);
    wr('h144, 32'h0); rd('h144);
    wr('h0FC, 32'hFFFFFFFF); rd('h0FC);
    wr('h0FC, 32'h00010000); rd('h0FC);
    // R9: simultaneous read and write returns the old value
    cyc(1, 1, 'h014, 32'h12345678, "R9"); rd('h014);
    cyc(1, 1, 'h070, 32'h80000000, "R9"); rd('h070);
    // R9: hold while idle
    rd('h098);
    repeat (4) begin
      @(negedge clk);
      check(bus_rdata === exp_rd, "R9 hold", bus_rdata, exp_rd);
    end
    // R7 R8: other reset configurations
    do_reset(32'hFFFF0000, 32'h0000FFFF, 3'd4);
    rd('h004, "R7"); rd('h07C, "R7"); rd('h09C, "R8"); rd('h070, "R4 cleared by reset");
    do_reset(32'h0, 32'h0, 3'd5);
    rd('h09C, "R8"); check(mdl[39] == 32'h1402, "R8 clamp", mdl[39], 32'h1402);
    do_reset(32'hA5A5A5A5, 32'h5A5A5A5A, 3'd7);
    rd('h09C, "R8"); rd('h004, "R7"); rd('h07C, "R7");
    do_reset(32'h0, 32'h1, 3'd0);
    rd('h09C, "R8"); rd('h06C, "R6");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule